// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage that sits behind one OR term of a sum-of-products logic array. The incoming sum goes either straight to the output or through a rising-edge D flip-flop. Two configuration bits choose between these paths and set the output polarity. The flip-flop is shared-controlled by a synchronous set term and an asynchronous clear term. When both are active, the clear takes priority.

The output is split into a data signal and a drive-enable signal. These stand in for a tri-state pad. A feedback signal goes back to the array. In registered modes the feedback is the flip-flop state. In combinational modes it is the value seen on the pin, so the pin can also serve as an input or as a bidirectional line.

Top module: `macrocell_io`

## Requirements
- R1: While `rst_n` is low the flip-flop state is 0, so a registered active-high output reads 0 and the registered feedback reads 0.
- R2: With set and clear inactive, the flip-flop takes the value of `sum_i` at each rising edge of `clk`. A registered output changes only after that edge.
- R3: When `set_i` is 1 and `clr_i` is 0 at a rising edge, the flip-flop becomes 1 whatever `sum_i` is.
- R4: When `clr_i` goes to 1, the flip-flop becomes 0 at once, without waiting for a clock edge. It stays 0 while `clr_i` remains 1.
- R5: When `set_i` and `clr_i` are both 1 across a rising edge, the flip-flop stays 0.
- R6: `cfg_pol` = 1 gives an active-high output, meaning `out_o` equals the selected value. `cfg_pol` = 0 gives an active-low output, meaning `out_o` is the inverse of the selected value.
- R7: `cfg_comb` = 0 selects the flip-flop as the output source. `cfg_comb` = 1 selects `sum_i` directly, and `out_o` then follows `sum_i` with no clock edge.
- R8: `fb_o` equals the flip-flop state when `cfg_comb` = 0 and equals `pin_i` when `cfg_comb` = 1.
- R9: `oe_o` is 1 exactly when `oe_term_i` is 1. When it is 0 the pin is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low power-on reset, clears the flip-flop |
| cfg_pol | input | 1 | 1 = active-high, 0 = active-low |
| cfg_comb | input | 1 | 1 = combinational, 0 = registered |
| sum_i | input | 1 | OR-term sum from the array |
| set_i | input | 1 | Shared synchronous set term |
| clr_i | input | 1 | Shared asynchronous clear term |
| oe_term_i | input | 1 | Output-enable product term |
| pin_i | input | 1 | Value observed on the pad |
| out_o | output | 1 | Output data toward the pad driver |
| oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The capture and set properties assume that the clear term does not pulse high and low again between two rising edges. Any clear pulse is held across at least one edge. The bench therefore raises the clear half-way through a cycle, checks its immediate effect, and only releases it after an edge has passed. All other inputs change at the falling edge, so each rising edge sees settled values.

// File: rtl/macrocell_io.sv
module macrocell_io #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pol,
  input  logic cfg_comb,
  input  logic sum_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic oe_term_i,
  input  logic pin_i,
  output logic out_o,
  output logic oe_o,
  output logic fb_o
);

  logic q_r;
  logic sel;

  always_ff @(posedge clk or posedge clr_i or negedge rst_n) begin
    if (!rst_n)      q_r <= RST_VAL;
    else if (clr_i)  q_r <= 1'b0;
    else if (set_i)  q_r <= 1'b1;
    else             q_r <= sum_i;
  end

  assign sel   = cfg_comb ? sum_i : q_r;
  assign out_o = cfg_pol ? sel : ~sel;
  assign oe_o  = oe_term_i;
  assign fb_o  = cfg_comb ? pin_i : q_r;

endmodule

// File: rtl/macrocell_io_chk.sv
module macrocell_io_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_pol,
  input logic cfg_comb,
  input logic sum_i,
  input logic set_i,
  input logic clr_i,
  input logic q,
  input logic out_o,
  input logic fb_o
);

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> (clr_i || q == $past(sum_i)));

  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> (clr_i || q));

  a_r4_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> !q);

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> (!q || !clr_i));

  a_r6_reg_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_comb |-> (out_o == (cfg_pol ? q : !q)));

  a_r8_reg_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_comb |-> (fb_o == q));

endmodule

bind macrocell_io macrocell_io_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_comb(cfg_comb),
  .sum_i(sum_i), .set_i(set_i), .clr_i(clr_i), .q(q_r),
  .out_o(out_o), .fb_o(fb_o)
);

// File: tb/macrocell_io_tb.sv
`timescale 1ns/1ps
module macrocell_io_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pol = 1'b1, cfg_comb = 1'b0;
  logic sum_i = 1'b0, set_i = 1'b0, clr_i = 1'b0, oe_term_i = 1'b0, pin_i = 1'b0;
  logic out_o, oe_o, fb_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  macrocell_io u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_comb(cfg_comb),
    .sum_i(sum_i), .set_i(set_i), .clr_i(clr_i), .oe_term_i(oe_term_i),
    .pin_i(pin_i), .out_o(out_o), .oe_o(oe_o), .fb_o(fb_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_then_settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #5;
    chk("R1 out", out_o, 1'b0);
    chk("R1 fb", fb_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_capture();
    @(negedge clk); cfg_pol = 1'b1; cfg_comb = 1'b0; sum_i = 1'b1; #1;
    chk("R2 before edge", out_o, 1'b0);
    edge_then_settle();
    chk("R2 captured 1", out_o, 1'b1);
    chk("R8 reg fb", fb_o, 1'b1);
    @(negedge clk); sum_i = 1'b0;
    edge_then_settle();
    chk("R2 captured 0", out_o, 1'b0);
  endtask

  task automatic t_polarity();
    @(negedge clk); cfg_pol = 1'b0; #1;
    chk("R6 reg active-low", out_o, 1'b1);
    @(negedge clk); cfg_comb = 1'b1; sum_i = 1'b1; #1;
    chk("R6 comb active-low", out_o, 1'b0);
    @(negedge clk); cfg_pol = 1'b1; cfg_comb = 1'b0; sum_i = 1'b0;
  endtask

  task automatic t_set();
    @(negedge clk); set_i = 1'b1; sum_i = 1'b0;
    edge_then_settle();
    chk("R3 set", fb_o, 1'b1);
    @(negedge clk); set_i = 1'b0;
    edge_then_settle();
    chk("R3 release", fb_o, 1'b0);
  endtask

  task automatic t_clear();
    @(negedge clk); sum_i = 1'b1;
    edge_then_settle();
    chk("R4 preload", fb_o, 1'b1);
    #4 clr_i = 1'b1; #1;
    chk("R4 async clear", fb_o, 1'b0);
    @(negedge clk); set_i = 1'b1;
    edge_then_settle();
    chk("R5 clear over set", fb_o, 1'b0);
    chk("R5 output", out_o, 1'b0);
    @(negedge clk); clr_i = 1'b0; set_i = 1'b0; sum_i = 1'b0;
    edge_then_settle();
    chk("R4 after release", fb_o, 1'b0);
  endtask

  task automatic t_comb();
    @(negedge clk); cfg_comb = 1'b1; cfg_pol = 1'b1; pin_i = 1'b1; sum_i = 1'b1; #1;
    chk("R7 comb follows 1", out_o, 1'b1);
    chk("R8 pin fb 1", fb_o, 1'b1);
    #3 sum_i = 1'b0; pin_i = 1'b0; #1;
    chk("R7 comb follows 0", out_o, 1'b0);
    chk("R8 pin fb 0", fb_o, 1'b0);
    @(negedge clk); cfg_comb = 1'b0;
  endtask

  task automatic t_oe();
    @(negedge clk); oe_term_i = 1'b0; #1;
    chk("R9 disabled", oe_o, 1'b0);
    oe_term_i = 1'b1; #1;
    chk("R9 enabled", oe_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_polarity();
    t_set();
    t_clear();
    t_comb();
    t_oe();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule